// File: doc/BRIEF.md
# One-Shot Down-Counting Interval Timer

This block is a single 32-bit count-down timer behind a small register window. Software arms it in a fixed order. First it turns counting off and writes a start value. Then it clears any stale event and unmasks the interrupt. Last it turns counting back on. The count then falls by one on each pulse of a chosen tick strobe. When it runs out, the timer latches an event flag and raises a level interrupt. The flag stays set until software writes a clear.

The tick comes from one of four strobe inputs. These are one-cycle enables generated elsewhere from slow, crystal, core and peripheral clocks. A two-bit field in the control word picks which strobe drives the count. The bus is a plain single-cycle port: a write takes effect at the clock edge, and read data is combinational from the address. The timer is one-shot. After it expires it sits at zero until it is turned off and on again.

Top module: `oneshot_down_timer`

## Requirements
- R1: After reset every register reads 0: counting is off, the source select is 0, the interrupt is unmasked-off and no event is pending, so `irq` is 0.
- R2: The control word is at byte offset 0x0. Bit 0 turns counting on, and bits [5:4] select which `tick_src` bit drives the count (value s uses `tick_src[s]`). Both fields read back in place, and all other bits read 0.
- R3: The start value is at offset 0x4. A write there lands only while bit 0 of control is 0. A write made while counting is on leaves the stored value unchanged.
- R4: The count word is at offset 0x8. It reads 0 whenever control bit 0 is 0.
- R5: A control write that turns bit 0 from 0 to 1 loads the count with the start value. A tick in that same cycle is not counted, and pulses on unselected strobes never change the count.
- R6: With start value N ≥ 1, the count reads N−k after k selected ticks. The event flag sets on the N-th tick, where the count reads 0. After that the count stays at 0 and no later tick has any effect until counting is re-armed.
- R7: A start value of 0 sets the event flag on the first selected tick after arming.
- R8: The acknowledge word is at offset 0xC. Its bit 0 is an interrupt mask bit that reads back. `irq` equals the event flag ANDed with that bit, so clearing the bit hides the event without losing it.
- R9: Writing 1 to acknowledge bit 5 clears the event flag. Bit 5 always reads 0.
- R10: If a clear write and an expiring tick fall in the same cycle, the flag ends up set.
- R11: Turning control bit 0 off and back on re-arms the timer from the stored start value after an earlier expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_src | input | 4 | Tick strobes; one is selected by control [5:4] |
| irq | output | 1 | Level interrupt: event flag AND mask bit |

## Verification
The hardest case to reach is a clear write that lands in the exact cycle the count expires. Reaching it means placing the final selected tick on the same edge as the acknowledge write. The bench therefore arms with a start value of 1 and issues the clear write together with the first tick in one bus cycle. A related narrow window is the arming edge itself. The bench drives the selected strobe in the same cycle as the enabling control write, and checks that the count still reads the full start value afterwards.

// File: rtl/oneshot_down_timer.sv
module oneshot_down_timer #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [3:0]  tick_src,
  output logic        irq
);

  logic             en, ie, pend, running;
  logic [1:0]       csel;
  logic [CNT_W-1:0] reload, count;

  wire wr_ctrl = bus_we && bus_addr[3:2] == 2'd0;
  wire wr_rld  = bus_we && bus_addr[3:2] == 2'd1;
  wire wr_ack  = bus_we && bus_addr[3:2] == 2'd3;
  wire arm     = wr_ctrl && bus_wdata[0] && !en;
  wire stop    = wr_ctrl && !bus_wdata[0];
  wire tick    = tick_src[csel];
  wire step    = running && tick && !stop;
  wire expire  = step && count <= CNT_W'(1);
  wire unused_addr = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; csel <= 2'd0; ie <= 1'b0; pend <= 1'b0; running <= 1'b0;
      reload <= '0; count <= '0;
    end else begin
      if (wr_ctrl) begin
        en   <= bus_wdata[0];
        csel <= bus_wdata[5:4];
      end
      if (wr_rld && !en) reload <= bus_wdata[CNT_W-1:0];
      if (arm)                   count <= reload;
      else if (wr_rld && !en)    count <= '0;
      else if (step)             count <= (count == '0) ? '0 : count - 1'b1;
      if (arm)                   running <= 1'b1;
      else if (stop || expire)   running <= 1'b0;
      if (wr_ack) ie <= bus_wdata[0];
      if (expire)                       pend <= 1'b1;
      else if (wr_ack && bus_wdata[5])  pend <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = {26'd0, csel, 3'd0, en};
      2'd1:    bus_rdata = 32'(reload);
      2'd2:    bus_rdata = en ? 32'(count) : 32'd0;
      default: bus_rdata = {31'd0, ie};
    endcase
  end

  assign irq = pend & ie;

  // R3
  reload_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_rld) |=> $stable(reload));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !bus_we && count > CNT_W'(1)) |=> count == $past(count) - 1'b1);

  // R6
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !bus_we && count <= CNT_W'(1)) |=> (pend && !running && count == '0));

  // R6
  one_shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !bus_we) |=> $stable(count));

  // R10
  clear_vs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !wr_ctrl && count <= CNT_W'(1)) |=> pend);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && bus_wdata[5] && !running) |=> !pend);

  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wr_ack && !bus_wdata[5]) |=> pend);

endmodule

// File: tb/tb_oneshot_down_timer.sv
module tb_oneshot_down_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = 4'd0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  oneshot_down_timer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d, input logic [3:0] t);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_src = t;
    @(negedge clk);
    bus_we = 1'b0; tick_src = 4'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      check("R1", v, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 control readback
    cyc(1, 4'h0, 32'hFFFF_FFF1, 4'd0);
    rd(4'h0, v); check("R2", v, 32'h31);
    cyc(1, 4'h0, 32'h20, 4'd0);
    rd(4'h0, v); check("R2", v, 32'h20);

    // R3 reload locked while enabled, R4 count zero while disabled
    cyc(1, 4'h0, 32'h0, 4'd0);
    cyc(1, 4'h4, 32'd7, 4'd0);
    rd(4'h8, v); check("R4", v, 32'd0);
    cyc(1, 4'h0, 32'h1, 4'd0);
    cyc(1, 4'h4, 32'd2, 4'd0);
    rd(4'h4, v); check("R3", v, 32'd7);
    rd(4'h8, v); check("R3", v, 32'd7);
    cyc(1, 4'h0, 32'h0, 4'd0);
    rd(4'h8, v); check("R4", v, 32'd0);

    // R5 R6 R7 R11 sweep over source and start value
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 6; n++) begin
        int last;
        last = (n == 0) ? 1 : n;
        cyc(1, 4'h0, 32'h0, 4'd0);
        cyc(1, 4'h4, 32'(n), 4'd0);
        cyc(1, 4'hC, 32'h21, 4'd0);
        cyc(1, 4'h0, 32'((s << 4) | 1), 4'(1 << s));
        rd(4'h8, v); check("R5 same-cycle tick", v, 32'(n));
        check("R11 irq clear after rearm", {31'd0, irq}, 32'd0);
        cyc(0, 4'h8, 32'h0, 4'(~(1 << s)));
        rd(4'h8, v); check("R5 other sources", v, 32'(n));
        for (int k = 1; k <= last; k++) begin
          cyc(0, 4'h8, 32'h0, 4'(1 << s));
          rd(4'h8, v);
          check(n == 0 ? "R7" : "R6", v, (n > k) ? 32'(n - k) : 32'd0);
          check(n == 0 ? "R7 irq" : "R6 irq", {31'd0, irq}, (k == last) ? 32'd1 : 32'd0);
        end
        cyc(0, 4'h8, 32'h0, 4'hF);
        rd(4'h8, v); check("R6 one-shot hold", v, 32'd0);
        check("R6 irq hold", {31'd0, irq}, 32'd1);
      end
    end

    // R8 mask keeps pending
    cyc(1, 4'hC, 32'h0, 4'd0);
    check("R8 masked", {31'd0, irq}, 32'd0);
    rd(4'hC, v); check("R8 mask read", v, 32'd0);
    cyc(1, 4'hC, 32'h1, 4'd0);
    check("R8 unmasked", {31'd0, irq}, 32'd1);

    // R9 clear
    cyc(1, 4'hC, 32'h21, 4'd0);
    check("R9", {31'd0, irq}, 32'd0);
    rd(4'hC, v); check("R9 bit5 reads 0", v, 32'd1);

    // R10 clear coinciding with expiry
    cyc(1, 4'h0, 32'h0, 4'd0);
    cyc(1, 4'h4, 32'd1, 4'd0);
    cyc(1, 4'h0, 32'h1, 4'd0);
    cyc(1, 4'hC, 32'h21, 4'b0001);
    check("R10", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule